// File: doc/BRIEF.md
# Associative Memory Road Array

This block is a grid of track-finding roads laid out in rows and columns. Each road holds one stored word per detector layer (four layers), each with a per-bit don't-care mask, and a disable bit. It also holds a sticky match bit per layer and a threshold comparator. The block has two modes. In load mode, software-free test logic or a sequencer writes a road's layer words one at a time, chosen by row, column and layer. In run mode, each incoming hit word carries a 2-bit layer tag. It is compared in one cycle against the word of that layer in every road at once. A road that matches latches a per-layer match bit, and that bit stays set until the next event rearm.

A road raises its flag when enough of its layers have matched to meet a shared threshold, unless the road is disabled. Results are read one row at a time. A row address selects one row, and the flags of all its columns appear on a registered bus one cycle later. After each switch from load mode to run mode, an event rearm must be given before any hit is accepted. This stops matches latched against half-loaded patterns from ever counting.

Top module: `amr_road_array`

## Requirements
- R1: After reset, every stored word and mask is zero, every road is enabled, all match bits are clear, the threshold is 4, the block is disarmed and `flags_o` is all zero.
- R2: In load mode (`run_mode`=0), a `load_en` cycle writes `load_word` and `load_dc` into layer `load_layer` of the road at (`load_row`, `load_col`) only, and sets that road's disable bit to `load_off`.
- R3: In run mode (`run_mode`=1), `load_en` has no effect on any road.
- R4: Hits are ignored in load mode, and in run mode until a `rearm` cycle has been seen since the last cycle in load mode. A hit in the same cycle as `rearm` is ignored.
- R5: An accepted hit sets match bit `hit_layer` of every road whose word of that layer equals `hit_word` on all bits where the mask is 0. A mask bit of 1 means don't care. Words of other layers are never compared.
- R6: Match bits are sticky across hits, and a `rearm` cycle clears every match bit in the array.
- R7: A road flags when it is enabled and its count of set match bits is at least the threshold. A threshold of 0 acts as 1. `thr_we` loads `thr_val` in either mode.
- R8: A road whose disable bit is set never flags.
- R9: `flags_o` bit c is the flag of the road in column c of row `rd_row`. It is registered, so it shows the state as it was before the clock edge at which it updates.
- R10: A threshold above 4 makes every road silent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_mode | input | 1 | 0 = load mode, 1 = run mode |
| load_en | input | 1 | Write strobe for a road layer |
| load_row | input | ROW_W | Row of the road to write |
| load_col | input | COL_W | Column of the road to write |
| load_layer | input | 2 | Layer word to write |
| load_word | input | WORD_W | Pattern value |
| load_dc | input | WORD_W | Don't-care mask, 1 = ignore bit |
| load_off | input | 1 | Disable bit written into the road |
| hit_valid | input | 1 | Hit word present |
| hit_layer | input | 2 | Layer tag of the hit |
| hit_word | input | WORD_W | Hit value |
| rearm | input | 1 | Clear all matches and arm for hits |
| thr_we | input | 1 | Threshold write strobe |
| thr_val | input | THR_W | New threshold |
| rd_row | input | ROW_W | Row selected for readout |
| flags_o | output | COLS | Registered flags of the selected row |

## Verification
A corrupted stored word or mask shows up as a flag that is missing or extra in that road's row. It appears on the readout as soon as a hit for that layer has been sent and the row has been selected, which is two cycles after the hit. A match bit that fails to stick or fails to clear makes a road's flag depend on the threshold in the wrong way. Because of this, every hit set is read back under thresholds 0 through 5. An arming error shows up as flags after hits that should have been dropped. It can be seen on the first readout that follows.

// File: rtl/amr_pkg.sv
package amr_pkg;
  localparam int unsigned LAYERS = 4;
  localparam int unsigned TAG_W  = 2;
  localparam int unsigned CNT_W  = $clog2(LAYERS + 1);
  typedef logic [TAG_W-1:0] layer_t;
  typedef logic [CNT_W-1:0] count_t;
endpackage

// File: rtl/amr_onehot_dec.sv
module amr_onehot_dec #(
  parameter int unsigned N  = 4,
  localparam int unsigned AW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          en,
  input  logic [AW-1:0] sel,
  output logic [N-1:0]  oh
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign oh[i] = en && (sel == AW'(i));
  end
endmodule

// File: rtl/amr_road.sv
module amr_road
  import amr_pkg::*;
#(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  layer_t            wr_layer,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [WORD_W-1:0] wr_dc,
  input  logic              wr_off,
  input  logic              hit_en,
  input  layer_t            hit_layer,
  input  logic [WORD_W-1:0] hit_word,
  input  logic              clear,
  input  count_t            need,
  output logic              flag
);
  logic [WORD_W-1:0] word_q [LAYERS];
  logic [WORD_W-1:0] dc_q   [LAYERS];
  logic              off_q;
  logic [LAYERS-1:0] lat_q;
  logic [LAYERS-1:0] hit_vec;
  count_t            cnt;

  for (genvar l = 0; l < LAYERS; l++) begin : g_cmp
    assign hit_vec[l] = hit_en && (hit_layer == TAG_W'(l)) &&
                        (((hit_word ^ word_q[l]) & ~dc_q[l]) == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < LAYERS; l++) begin
        word_q[l] <= '0;
        dc_q[l]   <= '0;
      end
      off_q <= 1'b0;
      lat_q <= '0;
    end else begin
      if (wr_en) begin
        word_q[wr_layer] <= wr_word;
        dc_q[wr_layer]   <= wr_dc;
        off_q            <= wr_off;
      end
      if (clear)       lat_q <= '0;
      else if (hit_en) lat_q <= lat_q | hit_vec;
    end
  end

  always_comb begin
    cnt = '0;
    for (int l = 0; l < LAYERS; l++) cnt = cnt + CNT_W'(lat_q[l]);
  end

  assign flag = !off_q && (need != '0) && (cnt >= need);

  // R6: a latched layer match survives until a clear
  for (genvar l = 0; l < LAYERS; l++) begin : g_chk
    a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
      (lat_q[l] && !clear) |=> lat_q[l]);
  end
  a_r6_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> (lat_q == '0));
  // R4: without an accepted hit the match bits do not move
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!hit_en && !clear) |=> $stable(lat_q));
endmodule

// File: rtl/amr_road_array.sv
module amr_road_array
  import amr_pkg::*;
#(
  parameter int unsigned ROWS   = 8,
  parameter int unsigned COLS   = 8,
  parameter int unsigned WORD_W = 8,
  localparam int unsigned ROW_W = $clog2(ROWS),
  localparam int unsigned COL_W = $clog2(COLS),
  localparam int unsigned THR_W = CNT_W,
  localparam int unsigned NROAD = ROWS * COLS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run_mode,
  input  logic              load_en,
  input  logic [ROW_W-1:0]  load_row,
  input  logic [COL_W-1:0]  load_col,
  input  logic [TAG_W-1:0]  load_layer,
  input  logic [WORD_W-1:0] load_word,
  input  logic [WORD_W-1:0] load_dc,
  input  logic              load_off,
  input  logic              hit_valid,
  input  logic [TAG_W-1:0]  hit_layer,
  input  logic [WORD_W-1:0] hit_word,
  input  logic              rearm,
  input  logic              thr_we,
  input  logic [THR_W-1:0]  thr_val,
  input  logic [ROW_W-1:0]  rd_row,
  output logic [COLS-1:0]   flags_o
);
  logic             armed_q;
  logic [THR_W-1:0] thr_q;
  count_t           need;
  logic             wr_go, hit_go;
  logic [ROWS-1:0]  wr_row_oh, rd_row_oh;
  logic [COLS-1:0]  wr_col_oh;
  logic [NROAD-1:0] we_flat;
  logic [COLS-1:0]  flag_rows [ROWS];
  logic [COLS-1:0]  row_sel;

  assign wr_go  = !run_mode && load_en;
  assign hit_go = run_mode && armed_q && hit_valid && !rearm;

  always_comb begin
    if (thr_q == '0)                    need = count_t'(1);
    else if (thr_q > THR_W'(LAYERS))    need = '0;
    else                                need = count_t'(thr_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      thr_q   <= THR_W'(LAYERS);
    end else begin
      armed_q <= run_mode && (armed_q || rearm);
      if (thr_we) thr_q <= thr_val;
    end
  end

  amr_onehot_dec #(.N(ROWS)) u_wr_row (.en(wr_go), .sel(load_row), .oh(wr_row_oh));
  amr_onehot_dec #(.N(COLS)) u_wr_col (.en(1'b1),  .sel(load_col), .oh(wr_col_oh));
  amr_onehot_dec #(.N(ROWS)) u_rd_row (.en(1'b1),  .sel(rd_row),   .oh(rd_row_oh));

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      assign we_flat[r*COLS + c] = wr_row_oh[r] && wr_col_oh[c];
      amr_road #(.WORD_W(WORD_W)) u_road (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (we_flat[r*COLS + c]),
        .wr_layer  (load_layer),
        .wr_word   (load_word),
        .wr_dc     (load_dc),
        .wr_off    (load_off),
        .hit_en    (hit_go),
        .hit_layer (hit_layer),
        .hit_word  (hit_word),
        .clear     (rearm),
        .need      (need),
        .flag      (flag_rows[r][c])
      );
    end
  end

  always_comb begin
    row_sel = '0;
    for (int r = 0; r < ROWS; r++)
      if (rd_row_oh[r]) row_sel = row_sel | flag_rows[r];
  end

  always_ff @(posedge clk) begin
    if (rst) flags_o <= '0;
    else     flags_o <= row_sel;
  end

  // R2: at most one road takes a write in any cycle
  a_r2_one_road: assert property (@(posedge clk) disable iff (rst)
    $onehot0(we_flat));
  // R3: no road is written while searching
  a_r3_no_run_write: assert property (@(posedge clk) disable iff (rst)
    run_mode |-> (we_flat == '0));
  // R4: a cycle in load mode leaves the array disarmed
  a_r4_disarm: assert property (@(posedge clk) disable iff (rst)
    !run_mode |=> !armed_q);
  // R6: two cycles after a rearm the readout is blank
  a_r6_blank: assert property (@(posedge clk) disable iff (rst)
    rearm |=> ##1 (flags_o == '0));
endmodule

// File: tb/amr_road_array_bench.sv
`timescale 1ns/1ps
module amr_road_array_bench;
  localparam int R = 4, C = 4, W = 8, L = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic run_mode = 0, load_en = 0, load_off = 0, hit_valid = 0;
  logic rearm = 0, thr_we = 0;
  logic [1:0] load_row = 0, load_col = 0, rd_row = 0;
  logic [1:0] load_layer = 0, hit_layer = 0;
  logic [W-1:0] load_word = 0, load_dc = 0, hit_word = 0;
  logic [2:0] thr_val = 0;
  logic [C-1:0] flags_o;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] m_word [R][C][L];
  logic [W-1:0] m_dc   [R][C][L];
  bit m_off [R][C];
  bit m_lat [R][C][L];
  int m_thr = 4;
  bit m_armed = 0, m_run = 0;
  int unsigned seed = 32'h1234_5678;

  always #4 clk = ~clk;

  amr_road_array #(.ROWS(R), .COLS(C), .WORD_W(W)) u_amr_road_array (
    .clk(clk), .rst(rst), .run_mode(run_mode), .load_en(load_en),
    .load_row(load_row), .load_col(load_col), .load_layer(load_layer),
    .load_word(load_word), .load_dc(load_dc), .load_off(load_off),
    .hit_valid(hit_valid), .hit_layer(hit_layer), .hit_word(hit_word),
    .rearm(rearm), .thr_we(thr_we), .thr_val(thr_val), .rd_row(rd_row),
    .flags_o(flags_o));

  function automatic logic [W-1:0] pat(int r, int c, int l);
    return W'(8'h40 + r*16 + c*4 + l);
  endfunction

  function automatic logic [C-1:0] exp_row(int r);
    logic [C-1:0] e;
    for (int c = 0; c < C; c++) begin
      int cnt = 0;
      int need = (m_thr == 0) ? 1 : m_thr;
      for (int l = 0; l < L; l++) cnt += m_lat[r][c][l];
      e[c] = !m_off[r][c] && (m_thr <= L) && (cnt >= need);
    end
    return e;
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic compare(logic [C-1:0] got, logic [C-1:0] exp, string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s flags got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic check_row(int r, string tag);
    rd_row = 2'(r);
    tick();
    compare(flags_o, exp_row(r), tag);
  endtask

  task automatic check_all(string tag);
    for (int r = 0; r < R; r++) check_row(r, tag);
  endtask

  task automatic apply_hit(int l, logic [W-1:0] w);
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++)
        if (((w ^ m_word[r][c][l]) & ~m_dc[r][c][l]) == '0) m_lat[r][c][l] = 1;
  endtask

  task automatic clear_lat();
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++)
        for (int l = 0; l < L; l++) m_lat[r][c][l] = 0;
  endtask

  task automatic do_load(int r, int c, int l, logic [W-1:0] w, logic [W-1:0] dc, bit off);
    load_en = 1; load_row = 2'(r); load_col = 2'(c); load_layer = 2'(l);
    load_word = w; load_dc = dc; load_off = off;
    tick();
    load_en = 0;
    if (!m_run) begin
      m_word[r][c][l] = w; m_dc[r][c][l] = dc; m_off[r][c] = off;
    end
  endtask

  task automatic do_hit(int l, logic [W-1:0] w);
    hit_valid = 1; hit_layer = 2'(l); hit_word = w;
    tick();
    hit_valid = 0;
    if (m_run && m_armed) apply_hit(l, w);
  endtask

  task automatic set_run(bit v);
    run_mode = v;
    tick();
    m_run = v;
    if (!v) m_armed = 0;
  endtask

  task automatic do_rearm(bit with_hit, int l, logic [W-1:0] w);
    rearm = 1; hit_valid = with_hit; hit_layer = 2'(l); hit_word = w;
    tick();
    rearm = 0; hit_valid = 0;
    clear_lat();
    if (m_run) m_armed = 1;
  endtask

  task automatic set_thr(int t);
    thr_we = 1; thr_val = 3'(t);
    tick();
    thr_we = 0;
    m_thr = t;
  endtask

  initial begin
    #(8.0 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++) begin
        m_off[r][c] = 0;
        for (int l = 0; l < L; l++) begin
          m_word[r][c][l] = '0; m_dc[r][c][l] = '0; m_lat[r][c][l] = 0;
        end
      end
    @(negedge clk); tick(); tick();
    rst = 0;

    // R1: reset state reads back all zero
    check_all("R1");
    // R4: hit before any rearm in run mode is dropped
    set_run(1);
    do_hit(0, 8'h00);
    set_thr(1);
    check_all("R4");
    // R1: reset patterns are zero, so layer 0 hit 0 matches every road
    do_rearm(0, 0, 0);
    do_hit(0, 8'h00);
    check_all("R1");
    // R7: threshold 4 with one layer matched
    set_thr(4);
    check_all("R7");

    // R2: load every road; one masked layer, one disabled road
    set_run(0);
    do_hit(1, 8'h00);
    for (int r = 0; r < R; r++)
      for (int c = 0; c < C; c++)
        for (int l = 0; l < L; l++)
          do_load(r, c, l, pat(r, c, l),
                  (r == 1 && c == 2 && l == 3) ? 8'h0F : 8'h00,
                  (r == 2 && c == 1));
    set_run(1);
    do_hit(1, pat(0, 0, 1));
    set_thr(1);
    check_all("R4");
    do_rearm(0, 0, 0);
    do_hit(0, pat(2, 3, 0));
    check_all("R2");

    // R3: load during run has no effect
    do_load(0, 0, 0, 8'hFF, 8'h00, 1'b1);
    do_hit(0, pat(0, 0, 0));
    check_row(0, "R3");
    // R8: disabled road matched on all layers stays silent
    for (int l = 0; l < L; l++) do_hit(l, pat(2, 1, l));
    check_row(2, "R8");
    // R6 and R4: rearm clears, and a hit in the same cycle is dropped
    do_rearm(1, 0, pat(1, 1, 0));
    check_all("R6");
    // R5: a layer 0 word tagged as layer 1 matches nothing
    do_hit(1, pat(3, 3, 0));
    check_row(3, "R5");
    // R5: don't-care bits let a near value match
    do_hit(3, 8'h5A);
    check_row(1, "R5");

    // R9: readout lags the edge that latches a hit
    do_rearm(0, 0, 0);
    rd_row = 2'd0; hit_valid = 1; hit_layer = 2'd2; hit_word = pat(0, 3, 2);
    tick();
    hit_valid = 0;
    compare(flags_o, 4'b0000, "R9");
    apply_hit(2, pat(0, 3, 2));
    tick();
    compare(flags_o, 4'b1000, "R9");

    // R7, R10, R6: sweep of hit sets against all thresholds
    for (int round = 0; round < 12; round++) begin
      do_rearm(0, 0, 0);
      for (int h = 0; h < 7; h++) begin
        int r, c, l, lw;
        seed = seed * 32'd1103515245 + 32'd12345;
        r = int'(seed[17:16]); c = int'(seed[19:18]);
        l = int'(seed[21:20]); lw = (seed[25:22] == 0) ? int'(seed[27:26]) : l;
        do_hit(l, pat(r, c, lw));
      end
      for (int t = 0; t <= 5; t++) begin
        set_thr(t);
        check_all(t == 5 ? "R10" : "R7");
      end
      set_thr(1);
      check_all("R6");
    end
    do_rearm(0, 0, 0);
    check_all("R6");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule